// File: doc/BRIEF.md
# Shared-Pin Parallel Port Write Sequencer

This block generates the write side of a 16-bit parallel port whose address and data travel over one shared set of AD pins. A host hands over a write request (a start address and a word count) through a valid/ready handshake, and then supplies data words through a second valid/ready channel as the sequencer asks for them. The sequencer drives an address latch enable pulse with the address on the bus, then switches the bus to data and produces one or more active-low write strobes.

All bus phases are counted in peripheral clock periods, each of which spans a fixed number of core clocks (two by default). The strobe width comes from a programmable 5-bit data-cycle duration D. A flash option takes 7 peripheral clocks away from the strobe and adds them to the gap between strobes. A hold option keeps the data on the bus for one extra peripheral clock after the strobe. The latch enable polarity can be selected, and a mode bit picks between one strobe per address phase and a burst of strobes behind a single address phase. Configuration is taken only while the port is idle or accepting a request, and it is then frozen until the transfer ends.

Top module: `mux_ad_write_seq`

## Requirements
- R1: During and after synchronous reset, `ale_o` is 0, `wr_n_o` is 1, `ad_oe_o` is 0 and `done_o` is 0.
- R2: The latch enable is active for exactly 2 peripheral clocks (4 core clocks). The address is on `ad_o` while it is active and for 1 peripheral clock after it deasserts.
- R3: The write strobe falls 2 peripheral clocks after the latch enable deasserts. The data word is on `ad_o` from 1 peripheral clock before the strobe falls, and the strobe is never low while the latch enable is active.
- R4: The strobe stays low for D−F peripheral clocks. D is `cfg_dur`, F is 7 with `cfg_flash` set and 0 otherwise.
- R5: A D below its legal minimum is raised to that minimum: 9 in flash mode, 1 otherwise. With flash set and D=4 the strobe is low for 2 peripheral clocks, and with flash clear and D=0 it is low for 1.
- R6: With `cfg_hold` set, the data stays driven for 1 peripheral clock after the strobe rises. With it clear and no further word or request pending, the bus is released (`ad_oe_o`=0) in the cycle the strobe rises.
- R7: With `cfg_multi`=1, one address phase is followed by `req_count` strobes (a count of 0 counts as 1), each carrying the next data word. From one strobe rising edge to the next falling edge is F+H+1 peripheral clocks, with H=1 if hold is set and 0 otherwise.
- R8: With `cfg_multi`=0, every request yields exactly one strobe whatever `req_count` is. A request that is waiting when the previous transfer ends gets its latch enable H peripheral clocks after the strobe rises.
- R9: `cfg_ale_low`=1 makes the latch enable active low: `ale_o` idles at 1 and drops to 0 for the 2-peripheral-clock pulse.
- R10: Changing the configuration inputs during a transfer has no effect on that transfer's strobe width or hold.
- R11: `done_o` pulses for one core clock when a transfer ends: in the cycle the last strobe rises when hold is clear, one peripheral clock later when hold is set.
- R12: If no data word is offered when one is needed, the strobe waits with the bus held, and it falls only after the word has been on the bus for 1 peripheral clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dur | input | 5 | Data-cycle duration D in peripheral clocks |
| cfg_hold | input | 1 | Adds one peripheral clock of data hold after each strobe |
| cfg_flash | input | 1 | Flash timing: strobe shortened and gap lengthened by 7 |
| cfg_ale_low | input | 1 | Latch enable active low when 1 |
| cfg_multi | input | 1 | 1: several strobes per address phase; 0: one |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Request accepted in this cycle |
| req_addr | input | 16 | Address of the request |
| req_count | input | 8 | Number of words (multi mode only) |
| dat_valid | input | 1 | Data word offered |
| dat_ready | output | 1 | Data word taken in this cycle |
| dat_word | input | 16 | Data word |
| ale_o | output | 1 | Address latch enable pin |
| wr_n_o | output | 1 | Active-low write strobe pin |
| ad_o | output | 16 | Shared address/data bus value |
| ad_oe_o | output | 1 | Output enable for the shared bus |
| done_o | output | 1 | One-cycle pulse at the end of a transfer |

## Verification
Single transfers are run with small, mid-range and flash-range durations and with values below the minimum. These separate the strobe width formula from the clamp and show whether F is subtracted only in flash mode. Bursts with hold set and with flash set test the gap formula F+H+1, and each strobe is matched against its own word, so a mix-up of gap terms or of word order shows up. Runs with and without hold, a back-to-back request, a late data word, inverted latch polarity and a configuration change during a transfer tell apart the hold path, the chained start, the stall path, the polarity inversion and the configuration freeze.

// File: rtl/ad_mux_pkg.sv
`timescale 1ns/1ps
package ad_mux_pkg;

  // Bus phases of the write sequence, in the order a transfer visits them.
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_ALE    = 3'd1,
    PH_AHOLD  = 3'd2,
    PH_WAIT   = 3'd3,
    PH_SETUP  = 3'd4,
    PH_STROBE = 3'd5,
    PH_DHOLD  = 3'd6,
    PH_FGAP   = 3'd7
  } phase_e;

  // Fixed phase lengths in peripheral clocks.
  localparam int ALE_PCLK_DEF   = 2;
  localparam int AHOLD_PCLK_DEF = 1;
  localparam int SETUP_PCLK_DEF = 1;

endpackage

// File: rtl/ad_mux_pclk_div.sv
`timescale 1ns/1ps
module ad_mux_pclk_div #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV > 1) begin : g_div
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else if (cnt_q == CW'(DIV - 1)) cnt_q <= '0;
        else cnt_q <= cnt_q + CW'(1);
      end
      assign tick = (cnt_q == CW'(DIV - 1));

      // R4
      tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end else begin : g_nodiv
      assign tick = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/ad_mux_timing.sv
`timescale 1ns/1ps
module ad_mux_timing #(
  parameter int DUR_W       = 5,
  parameter int FLASH_EXTRA = 7,
  parameter int FLASH_DMIN  = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DUR_W-1:0] dur_i,
  input  logic             hold_i,
  input  logic             flash_i,
  input  logic             ale_low_i,
  output logic             ale_low_q,
  output logic [DUR_W-1:0] wr_len,
  output logic [DUR_W-1:0] hold_len,
  output logic [DUR_W-1:0] gap_len
);
  logic [DUR_W-1:0] dur_q;
  logic             hold_q;
  logic             flash_q;
  logic [DUR_W-1:0] dmin;
  logic [DUR_W-1:0] eff;

  // Configuration is captured only while the sequencer allows it.
  always_ff @(posedge clk) begin
    if (rst) begin
      dur_q     <= '0;
      hold_q    <= 1'b0;
      flash_q   <= 1'b0;
      ale_low_q <= 1'b0;
    end else if (load) begin
      dur_q     <= dur_i;
      hold_q    <= hold_i;
      flash_q   <= flash_i;
      ale_low_q <= ale_low_i;
    end
  end

  always_comb begin
    dmin     = flash_q ? DUR_W'(FLASH_DMIN) : DUR_W'(1);
    eff      = (dur_q < dmin) ? dmin : dur_q;
    wr_len   = flash_q ? (eff - DUR_W'(FLASH_EXTRA)) : eff;
    hold_len = hold_q ? DUR_W'(1) : '0;
    gap_len  = flash_q ? DUR_W'(FLASH_EXTRA) : '0;
  end

  // R5
  strobe_floor_chk: assert property (@(posedge clk) disable iff (rst)
    wr_len >= DUR_W'(1));
  // R5
  flash_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (gap_len != '0) |-> (wr_len >= DUR_W'(FLASH_DMIN - FLASH_EXTRA)));

endmodule

// File: rtl/ad_mux_phase_fsm.sv
`timescale 1ns/1ps
module ad_mux_phase_fsm
  import ad_mux_pkg::*;
#(
  parameter int AD_W        = 16,
  parameter int CNT_W       = 8,
  parameter int LEN_W       = 5,
  parameter int ALE_PCLK    = ALE_PCLK_DEF,
  parameter int AHOLD_PCLK  = AHOLD_PCLK_DEF,
  parameter int SETUP_PCLK  = SETUP_PCLK_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             req_valid,
  input  logic [AD_W-1:0]  req_addr,
  input  logic [CNT_W-1:0] req_count,
  input  logic             multi,
  input  logic [LEN_W-1:0] wr_len,
  input  logic [LEN_W-1:0] hold_len,
  input  logic [LEN_W-1:0] gap_len,
  input  logic             dat_valid,
  input  logic [AD_W-1:0]  dat_word,
  output logic             req_ready,
  output logic             dat_ready,
  output logic             cfg_load,
  output phase_e           st_d,
  output logic [AD_W-1:0]  addr_d,
  output logic [AD_W-1:0]  data_d,
  output logic             done_o
);
  phase_e           st_q;
  logic [AD_W-1:0]  addr_q, data_q;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic [LEN_W-1:0] cnt_q, plen;
  logic             phase_end;
  logic             go_setup, finish, accept;

  always_comb begin
    unique case (st_q)
      PH_ALE:    plen = LEN_W'(ALE_PCLK);
      PH_AHOLD:  plen = LEN_W'(AHOLD_PCLK);
      PH_SETUP:  plen = LEN_W'(SETUP_PCLK);
      PH_STROBE: plen = wr_len;
      PH_DHOLD:  plen = hold_len;
      PH_FGAP:   plen = gap_len;
      default:   plen = LEN_W'(1);
    endcase
  end

  assign phase_end = tick && (cnt_q == plen - LEN_W'(1));

  always_comb begin
    st_d      = st_q;
    addr_d    = addr_q;
    data_d    = data_q;
    rem_d     = rem_q;
    req_ready = 1'b0;
    dat_ready = 1'b0;
    go_setup  = 1'b0;
    finish    = 1'b0;
    accept    = 1'b0;
    if (phase_end) begin
      unique case (st_q)
        PH_IDLE:  accept = req_valid;
        PH_ALE:   st_d = PH_AHOLD;
        PH_AHOLD: go_setup = 1'b1;
        PH_WAIT:  go_setup = 1'b1;
        PH_SETUP: st_d = PH_STROBE;
        PH_STROBE: begin
          rem_d = rem_q - CNT_W'(1);
          if (hold_len != '0) st_d = PH_DHOLD;
          else if (rem_q > CNT_W'(1)) begin
            if (gap_len != '0) st_d = PH_FGAP;
            else go_setup = 1'b1;
          end else finish = 1'b1;
        end
        PH_DHOLD: begin
          if (rem_q != '0) begin
            if (gap_len != '0) st_d = PH_FGAP;
            else go_setup = 1'b1;
          end else finish = 1'b1;
        end
        PH_FGAP:  go_setup = 1'b1;
        default:  st_d = PH_IDLE;
      endcase
    end
    if (go_setup) begin
      if (dat_valid) begin
        dat_ready = 1'b1;
        data_d    = dat_word;
        st_d      = PH_SETUP;
      end else begin
        st_d = PH_WAIT;
      end
    end
    if (finish) begin
      st_d   = PH_IDLE;
      accept = req_valid;
    end
    if (accept) begin
      req_ready = 1'b1;
      st_d      = PH_ALE;
      addr_d    = req_addr;
      rem_d     = (multi && req_count != '0) ? req_count : CNT_W'(1);
    end
  end

  assign cfg_load = (st_q == PH_IDLE) || accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= PH_IDLE;
      addr_q <= '0;
      data_q <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      data_q <= data_d;
      rem_q  <= rem_d;
      done_o <= finish;
      if (tick) cnt_q <= phase_end ? '0 : cnt_q + LEN_W'(1);
    end
  end

  // R4
  phase_cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q < plen);
  // R8
  req_dat_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_ready && dat_ready));
  // R4
  ready_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (req_ready || dat_ready) |-> tick);

endmodule

// File: rtl/ad_mux_pin_drv.sv
`timescale 1ns/1ps
module ad_mux_pin_drv
  import ad_mux_pkg::*;
#(
  parameter int AD_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  phase_e          st_d,
  input  logic [AD_W-1:0] addr_d,
  input  logic [AD_W-1:0] data_d,
  input  logic            ale_low,
  output logic            ale_o,
  output logic            wr_n_o,
  output logic [AD_W-1:0] ad_o,
  output logic            ad_oe_o
);
  logic addr_phase;
  assign addr_phase = (st_d == PH_ALE) || (st_d == PH_AHOLD);

  // Pins are decoded from the next phase so every one leaves a flop.
  always_ff @(posedge clk) begin
    if (rst) begin
      ale_o   <= 1'b0;
      wr_n_o  <= 1'b1;
      ad_o    <= '0;
      ad_oe_o <= 1'b0;
    end else begin
      ale_o   <= (st_d == PH_ALE) ^ ale_low;
      wr_n_o  <= (st_d != PH_STROBE);
      ad_oe_o <= (st_d != PH_IDLE);
      ad_o    <= addr_phase ? addr_d : ((st_d == PH_IDLE) ? '0 : data_d);
    end
  end

  // R6
  strobe_drives_bus_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_n_o |-> ad_oe_o);

endmodule

// File: rtl/mux_ad_write_seq.sv
`timescale 1ns/1ps
module mux_ad_write_seq
  import ad_mux_pkg::*;
#(
  parameter int AD_W     = 16,
  parameter int DUR_W    = 5,
  parameter int CNT_W    = 8,
  parameter int PCLK_DIV = 2,
  parameter int FLASH_EXTRA = 7,
  parameter int FLASH_DMIN  = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DUR_W-1:0] cfg_dur,
  input  logic             cfg_hold,
  input  logic             cfg_flash,
  input  logic             cfg_ale_low,
  input  logic             cfg_multi,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AD_W-1:0]  req_addr,
  input  logic [CNT_W-1:0] req_count,
  input  logic             dat_valid,
  output logic             dat_ready,
  input  logic [AD_W-1:0]  dat_word,
  output logic             ale_o,
  output logic             wr_n_o,
  output logic [AD_W-1:0]  ad_o,
  output logic             ad_oe_o,
  output logic             done_o
);
  logic             tick;
  logic             cfg_load;
  logic             ale_low_q;
  logic [DUR_W-1:0] wr_len, hold_len, gap_len;
  phase_e           st_d;
  logic [AD_W-1:0]  addr_d, data_d;

  ad_mux_pclk_div #(.DIV(PCLK_DIV)) u_div (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  ad_mux_timing #(
    .DUR_W      (DUR_W),
    .FLASH_EXTRA(FLASH_EXTRA),
    .FLASH_DMIN (FLASH_DMIN)
  ) u_timing (
    .clk      (clk),
    .rst      (rst),
    .load     (cfg_load),
    .dur_i    (cfg_dur),
    .hold_i   (cfg_hold),
    .flash_i  (cfg_flash),
    .ale_low_i(cfg_ale_low),
    .ale_low_q(ale_low_q),
    .wr_len   (wr_len),
    .hold_len (hold_len),
    .gap_len  (gap_len)
  );

  ad_mux_phase_fsm #(
    .AD_W (AD_W),
    .CNT_W(CNT_W),
    .LEN_W(DUR_W)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .req_valid(req_valid),
    .req_addr (req_addr),
    .req_count(req_count),
    .multi    (cfg_multi),
    .wr_len   (wr_len),
    .hold_len (hold_len),
    .gap_len  (gap_len),
    .dat_valid(dat_valid),
    .dat_word (dat_word),
    .req_ready(req_ready),
    .dat_ready(dat_ready),
    .cfg_load (cfg_load),
    .st_d     (st_d),
    .addr_d   (addr_d),
    .data_d   (data_d),
    .done_o   (done_o)
  );

  ad_mux_pin_drv #(.AD_W(AD_W)) u_pins (
    .clk    (clk),
    .rst    (rst),
    .st_d   (st_d),
    .addr_d (addr_d),
    .data_d (data_d),
    .ale_low(ale_low_q),
    .ale_o  (ale_o),
    .wr_n_o (wr_n_o),
    .ad_o   (ad_o),
    .ad_oe_o(ad_oe_o)
  );

  // R3
  ale_strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !((ale_o ^ ale_low_q) && !wr_n_o));
  // R4
  strobe_on_pclk_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(wr_n_o) |-> $past(tick));
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R2
  ale_on_pclk_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(ad_oe_o)) |-> (ale_o ^ ale_low_q));

endmodule

// File: tb/mux_ad_write_seq_tb_top.sv
`timescale 1ns/1ps
module mux_ad_write_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  cfg_dur = 5'd5;
  logic        cfg_hold = 1'b0, cfg_flash = 1'b0, cfg_ale_low = 1'b0, cfg_multi = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_count = '0;
  logic        dat_valid = 1'b0;
  logic        dat_ready;
  logic [15:0] dat_word = '0;
  logic        ale_o, wr_n_o, ad_oe_o, done_o;
  logic [15:0] ad_o;

  always #2.5 clk = ~clk;

  mux_ad_write_seq dut_i (
    .clk(clk), .rst(rst),
    .cfg_dur(cfg_dur), .cfg_hold(cfg_hold), .cfg_flash(cfg_flash),
    .cfg_ale_low(cfg_ale_low), .cfg_multi(cfg_multi),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_count(req_count),
    .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_word(dat_word),
    .ale_o(ale_o), .wr_n_o(wr_n_o), .ad_o(ad_o), .ad_oe_o(ad_oe_o),
    .done_o(done_o)
  );

  int nchk = 0, nerr = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Event log taken at falling edges.
  logic pol = 1'b0;
  int ar_t[32], af_t[32], wf_t[32], wrr_t[32], dn_t[32];
  int wf_m2[32], wf_m3[32], rise_ad[32], rise_oe[32];
  int nar = 0, naf = 0, nwf = 0, nwr = 0, ndn = 0;
  logic [15:0] h1 = '0, h2 = '0, h3 = '0;
  logic pw = 1'b1, pa = 1'b0;

  always @(negedge clk) begin
    logic act;
    if (!rst) begin
      act = ale_o ^ pol;
      if (act && !pa && nar < 32) begin ar_t[nar] = cyc; nar++; end
      if (!act && pa && naf < 32) begin af_t[naf] = cyc; naf++; end
      if (!wr_n_o && pw && nwf < 32) begin
        wf_t[nwf] = cyc; wf_m2[nwf] = int'(h2); wf_m3[nwf] = int'(h3); nwf++;
      end
      if (wr_n_o && !pw && nwr < 32) begin
        wrr_t[nwr] = cyc; rise_ad[nwr] = int'(ad_o); rise_oe[nwr] = int'(ad_oe_o); nwr++;
      end
      if (done_o && ndn < 32) begin dn_t[ndn] = cyc; ndn++; end
      h3 = h2; h2 = h1; h1 = ad_o; pw = wr_n_o; pa = act;
    end
  end

  // Data word source.
  logic [15:0] dq[16];
  int dq_n = 0, dq_idx = 0;
  logic dat_en = 1'b0;
  logic pend = 1'b0;
  always @(negedge clk) begin
    if (pend) dq_idx++;
    dat_valid = dat_en && (dq_idx < dq_n);
    dat_word  = (dq_idx < dq_n) ? dq[dq_idx] : 16'h0;
    #1 pend = dat_valid && dat_ready;
  end

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(negedge clk); #2;
    nar = 0; naf = 0; nwf = 0; nwr = 0; ndn = 0;
  endtask

  task automatic set_cfg(int d, bit h, bit f, bit al, bit m);
    @(negedge clk);
    cfg_dur = 5'(d); cfg_hold = h; cfg_flash = f; cfg_ale_low = al; cfg_multi = m;
    pol = al;
    repeat (4) @(negedge clk);
  endtask

  task automatic load_words(int n, logic [15:0] base);
    @(negedge clk); #2;
    for (int i = 0; i < n; i++) dq[i] = base + 16'(i * 16'h0111);
    dq_n = n; dq_idx = 0; dat_en = 1'b1;
  endtask

  task automatic send(logic [15:0] a, int c);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_count = 8'(c);
    forever begin
      #1;
      if (req_ready) break;
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(int n);
    int t = 0;
    while (ndn < n && t < 3000) begin @(negedge clk); t++; end
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 ale in reset", int'(ale_o), 0);
    chk("R1 wr_n in reset", int'(wr_n_o), 1);
    chk("R1 oe in reset", int'(ad_oe_o), 0);
    chk("R1 done in reset", int'(done_o), 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 wr_n after reset", int'(wr_n_o), 1);
    chk("R1 oe after reset", int'(ad_oe_o), 0);
  endtask

  task automatic t_basic();
    set_cfg(5, 0, 0, 0, 0);
    load_words(1, 16'h3C5A);
    clear_mon();
    send(16'hA10F, 1);
    wait_done(1);
    chk("R2 ale width", af_t[0] - ar_t[0], 4);
    chk("R2 addr after ale", wf_m3[0], 16'hA10F);
    chk("R3 ale fall to wr fall", wf_t[0] - af_t[0], 4);
    chk("R3 data setup", wf_m2[0], 16'h3C5A);
    chk("R4 wr low D=5", wrr_t[0] - wf_t[0], 10);
    chk("R6 bus released", rise_oe[0], 0);
    chk("R11 done at rise", dn_t[0] - wrr_t[0], 0);
    chk("R8 one strobe", nwf, 1);
  endtask

  task automatic t_hold();
    set_cfg(3, 1, 0, 0, 0);
    load_words(1, 16'h0FF0);
    clear_mon();
    send(16'h1357, 1);
    wait_done(1);
    chk("R4 wr low D=3", wrr_t[0] - wf_t[0], 6);
    chk("R6 data held", rise_ad[0], 16'h0FF0);
    chk("R6 bus held", rise_oe[0], 1);
    chk("R11 done after hold", dn_t[0] - wrr_t[0], 2);
  endtask

  task automatic t_flash();
    set_cfg(12, 0, 1, 0, 0);
    load_words(1, 16'h5A5A);
    clear_mon();
    send(16'h2468, 1);
    wait_done(1);
    chk("R4 flash wr low D=12", wrr_t[0] - wf_t[0], 10);
    chk("R3 flash ale to wr", wf_t[0] - af_t[0], 4);
  endtask

  task automatic t_clamp();
    set_cfg(4, 0, 1, 0, 0);
    load_words(1, 16'h1111);
    clear_mon();
    send(16'h0101, 1);
    wait_done(1);
    chk("R5 flash clamp D=4", wrr_t[0] - wf_t[0], 4);
    set_cfg(0, 0, 0, 0, 0);
    load_words(1, 16'h2222);
    clear_mon();
    send(16'h0202, 1);
    wait_done(1);
    chk("R5 normal clamp D=0", wrr_t[0] - wf_t[0], 2);
  endtask

  task automatic t_multi();
    set_cfg(4, 1, 0, 0, 1);
    load_words(3, 16'h4000);
    clear_mon();
    send(16'h7700, 3);
    wait_done(1);
    chk("R7 strobe count", nwf, 3);
    chk("R7 single address phase", nar, 1);
    for (int i = 0; i < 3; i++) begin
      chk("R7 burst wr low", wrr_t[i] - wf_t[i], 8);
      chk("R7 burst word", wf_m2[i], int'(16'h4000 + 16'(i * 16'h0111)));
    end
    for (int i = 0; i < 2; i++) chk("R7 gap F+H+1", wf_t[i+1] - wrr_t[i], 4);
    chk("R11 single done", ndn, 1);
  endtask

  task automatic t_multi_flash();
    set_cfg(9, 0, 1, 0, 1);
    load_words(2, 16'h8800);
    clear_mon();
    send(16'h3300, 2);
    wait_done(1);
    chk("R7 flash strobe count", nwf, 2);
    chk("R7 flash burst low", wrr_t[1] - wf_t[1], 4);
    chk("R7 flash gap", wf_t[1] - wrr_t[0], 16);
    chk("R7 flash second word", wf_m2[1], int'(16'h8911));
  endtask

  task automatic t_counts();
    set_cfg(2, 0, 0, 0, 1);
    load_words(2, 16'h0A00);
    clear_mon();
    send(16'h0B00, 0);
    wait_done(1);
    chk("R7 count zero one strobe", nwf, 1);
    set_cfg(2, 0, 0, 0, 0);
    load_words(4, 16'h0C00);
    clear_mon();
    send(16'h0D00, 4);
    wait_done(1);
    repeat (20) @(negedge clk);
    chk("R8 count ignored", nwf, 1);
  endtask

  task automatic t_b2b();
    set_cfg(3, 1, 0, 0, 0);
    load_words(2, 16'h6100);
    clear_mon();
    send(16'h6000, 1);
    send(16'h6800, 1);
    wait_done(2);
    chk("R8 two address phases", nar, 2);
    chk("R8 ale after H", ar_t[1] - wrr_t[0], 2);
    chk("R8 second addr", wf_m3[1], 16'h6800);
  endtask

  task automatic t_pol();
    set_cfg(5, 0, 0, 1, 0);
    load_words(1, 16'h9999);
    clear_mon();
    chk("R9 idle level high", int'(ale_o), 1);
    send(16'h4321, 1);
    wait_done(1);
    chk("R9 low pulse width", af_t[0] - ar_t[0], 4);
    chk("R9 back to idle high", int'(ale_o), 1);
    set_cfg(5, 0, 0, 0, 0);
  endtask

  task automatic t_freeze();
    set_cfg(6, 0, 0, 0, 0);
    load_words(1, 16'h7E7E);
    clear_mon();
    send(16'h5555, 1);
    cfg_dur = 5'd2; cfg_hold = 1'b1;
    wait_done(1);
    chk("R10 width frozen", wrr_t[0] - wf_t[0], 12);
    chk("R10 hold frozen", rise_oe[0], 0);
    set_cfg(5, 0, 0, 0, 0);
  endtask

  task automatic t_stall();
    int en_t;
    set_cfg(3, 0, 0, 0, 0);
    load_words(1, 16'hBEEF);
    dat_en = 1'b0;
    clear_mon();
    send(16'hCAFE, 1);
    repeat (12) @(negedge clk);
    en_t = cyc;
    chk("R12 no strobe while starved", nwf, 0);
    dat_en = 1'b1;
    wait_done(1);
    chk("R12 strobe after data", int'(wf_t[0] > en_t), 1);
    chk("R12 setup kept", wf_m2[0], 16'hBEEF);
    chk("R12 width", wrr_t[0] - wf_t[0], 6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_hold();
    t_flash();
    t_clamp();
    t_multi();
    t_multi_flash();
    t_counts();
    t_b2b();
    t_pol();
    t_freeze();
    t_stall();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule